// File: doc/BRIEF.md
# Serial Exponent-Bin Sum Reconstructor

Once a bank of per-exponent integer bins has finished collecting mantissas, their contents still have to be combined into a single number. This block does that combining. It reads the bins one at a time, starting at the lowest exponent and ending at the highest. Each bin is added into a signed running register. The low-order bits of that register then leave the block as the next result bits, and the register shifts right arithmetically. After the top bin has been read, whatever is left in the register forms the high-order part of the result. No rounding happens while the bins are being combined, so the full-width result is exact.

The bins sit in storage outside the block. The block fetches them through a request/index/acknowledge handshake. A bin whose significand is narrower than the common width comes with a left-pad count, and the block applies that pad before the bin is added. The result leaves the block in two ways. The first is a stream of bit chunks, one chunk per bin step. The second is the complete exact word on a parallel port. A parallel rounded value is also provided: the exact word is reduced to its top bits, with ties going to the even value. That is the single rounding in the whole flow. A one-cycle done pulse marks the end of a pass.

Setting the grouping parameter to k makes each bin step cover 2^k bit positions instead of one. The default setting uses one bit per bin.

Top module: `serial_bin_recon`

## Requirements
- R1: A start pulse seen while idle begins a pass. From the next cycle the block raises `bin_req` and presents bin indices 0, 1, …, NBINS-1 in increasing order. While `bin_ack` is low it keeps `bin_req` high and holds `bin_idx` unchanged. A bin is taken in a cycle where both `bin_req` and `bin_ack` are high.
- R2: In the cycle after bin j is taken, `bit_valid` is high for one cycle and `bit_data` equals bits [j*STEP +: STEP] of the exact sum. STEP is 2^GRP_K, which is 1 at the default settings.
- R3: When `done` is high, `sum_out` holds the exact sum Σ bin_j · 2^(pad_j + j·STEP). It is a two's-complement value of width SUM_W = NBINS·STEP + BIN_W + 1, and negative totals are kept correctly.
- R4: Each bin value is shifted left by its `bin_pad` count before it is added.
- R5: When `done` is high, `rnd_out` holds the top OUT_W bits of `sum_out`, rounded by the discarded low DROP = SUM_W − OUT_W bits. The value rounds up when the discarded part is above one half. On an exact half it rounds to the even value. Any set bit below the first discarded bit counts as above one half. At the default settings DROP is 17.
- R6: `done` is high for exactly one cycle. That cycle comes two cycles after the last bin is taken, and `bin_req` is low during it. `sum_out` does not change in the cycle after `done` unless a new start arrives.
- R7: A start pulse that arrives during a pass is ignored. Every new pass begins with the running register and the collected bits cleared.
- R8: After reset, `bin_req`, `bit_valid` and `done` are low, and `sum_out` and `rnd_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reconstruction pass (used only when idle) |
| bin_req | output | 1 | A bin read is outstanding |
| bin_idx | output | IDX_W | Index of the requested bin |
| bin_ack | input | 1 | Bin data is valid this cycle |
| bin_data | input | BIN_W | Signed bin contents |
| bin_pad | input | PAD_W | Left-pad count for this bin |
| bit_valid | output | 1 | `bit_data` carries a new chunk |
| bit_data | output | STEP | Next chunk of result bits, lowest first |
| sum_out | output | SUM_W | Exact reconstructed sum |
| rnd_out | output | OUT_W | Sum rounded to its top OUT_W bits |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The checks assume that the bin storage asserts `bin_ack` only while `bin_req` is high. They also assume that every bin value shifted by its pad still fits in BIN_W signed bits. One property checks this fit directly on every accepted bin. The bench acts as the bin storage. It replies only to a raised request, with zero to several cycles of latency. When it uses pads, it keeps the pads small and the data magnitudes small, so that the padded values never leave the bin range. Rounding ties and sticky cases are built by placing a value in the top bin only, so that the exact half point is known in advance.

// File: rtl/serial_bin_recon.sv
module serial_bin_recon #(
  parameter int NBINS = 16,
  parameter int BIN_W = 12,
  parameter int GRP_K = 0,
  parameter int OUT_W = 12,
  localparam int STEP  = 1 << GRP_K,
  localparam int ACC_W = BIN_W + 1,
  localparam int LO_W  = NBINS * STEP,
  localparam int SUM_W = LO_W + ACC_W,
  localparam int IDX_W = $clog2(NBINS),
  localparam int PAD_W = $clog2(BIN_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    bin_req,
  output logic [IDX_W-1:0]        bin_idx,
  input  logic                    bin_ack,
  input  logic signed [BIN_W-1:0] bin_data,
  input  logic [PAD_W-1:0]        bin_pad,
  output logic                    bit_valid,
  output logic [STEP-1:0]         bit_data,
  output logic [SUM_W-1:0]        sum_out,
  output logic [OUT_W-1:0]        rnd_out,
  output logic                    done
);

  localparam int DROP = SUM_W - OUT_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBINS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t                  st_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] acc_sum;
  logic [LO_W-1:0]         lo_q;
  logic [IDX_W-1:0]        idx_q;
  logic [OUT_W-1:0]        rnd_q;
  logic [OUT_W-1:0]        keep;
  logic                    round_up;
  logic                    take;

  assign take    = (st_q == S_RUN) && bin_ack;
  assign addend  = ACC_W'(bin_data) <<< bin_pad;
  assign acc_sum = acc_q + addend;

  assign sum_out  = {acc_q, lo_q};
  assign keep     = sum_out[SUM_W-1:DROP];
  assign round_up = sum_out[DROP-1] & ((|sum_out[DROP-2:0]) | keep[0]);

  assign bin_req = (st_q == S_RUN);
  assign bin_idx = idx_q;
  assign rnd_out = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      acc_q     <= '0;
      lo_q      <= '0;
      idx_q     <= '0;
      rnd_q     <= '0;
      done      <= 1'b0;
      bit_valid <= 1'b0;
      bit_data  <= '0;
    end else begin
      done      <= (st_q == S_FIN);
      bit_valid <= take;
      if (take) bit_data <= acc_sum[STEP-1:0];
      unique case (st_q)
        S_IDLE: if (start) begin
          acc_q <= '0;
          lo_q  <= '0;
          idx_q <= '0;
          st_q  <= S_RUN;
        end
        S_RUN: if (bin_ack) begin
          acc_q <= acc_sum >>> STEP;
          lo_q  <= {acc_sum[STEP-1:0], lo_q[LO_W-1:STEP]};
          if (idx_q == LAST) st_q <= S_FIN;
          else idx_q <= idx_q + IDX_W'(1);
        end
        S_FIN: begin
          rnd_q <= keep + OUT_W'(round_up);
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_bin_recon_chk.sv
module serial_bin_recon_chk #(
  parameter int NBINS = 16,
  parameter int BIN_W = 12,
  parameter int GRP_K = 0,
  parameter int OUT_W = 12
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             start,
  input logic                             bin_req,
  input logic [$clog2(NBINS)-1:0]         bin_idx,
  input logic                             bin_ack,
  input logic signed [BIN_W-1:0]          bin_data,
  input logic [$clog2(BIN_W)-1:0]         bin_pad,
  input logic                             bit_valid,
  input logic [NBINS*(1<<GRP_K)+BIN_W:0]  sum_out,
  input logic                             done
);
  localparam int IDX_W  = $clog2(NBINS);
  localparam int PAD_W  = $clog2(BIN_W);
  localparam int WIDE_W = BIN_W + (1 << PAD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBINS - 1);

  logic signed [WIDE_W-1:0] wide;
  assign wide = $signed(bin_data) <<< bin_pad;

  assert_first_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bin_req) |-> bin_idx == '0);

  assert_idx_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_req && bin_ack && bin_idx != LAST) |=> bin_req && bin_idx == $past(bin_idx) + IDX_W'(1));

  assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_req && !bin_ack) |=> bin_req && $stable(bin_idx));

  assert_bit_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_req && bin_ack) |=> bit_valid);

  assert_no_bit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bin_req && bin_ack) |=> !bit_valid);

  assert_pad_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_req && bin_ack) |-> wide == $signed(wide[BIN_W-1:0]));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bin_req);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(sum_out));

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_req && !bin_ack && start) |=> bin_req && $stable(bin_idx));
endmodule

bind serial_bin_recon serial_bin_recon_chk #(
  .NBINS(NBINS), .BIN_W(BIN_W), .GRP_K(GRP_K), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .bin_req(bin_req),
  .bin_idx(bin_idx), .bin_ack(bin_ack), .bin_data(bin_data),
  .bin_pad(bin_pad), .bit_valid(bit_valid), .sum_out(sum_out), .done(done)
);

// File: tb/serial_bin_recon_tb_top.sv
module serial_bin_recon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBINS = 16;
  localparam int BIN_W = 12;
  localparam int GRP_K = 0;
  localparam int OUT_W = 12;
  localparam int STEP  = 1 << GRP_K;
  localparam int SUM_W = NBINS * STEP + BIN_W + 1;
  localparam int IDX_W = $clog2(NBINS);
  localparam int PAD_W = $clog2(BIN_W);
  localparam int DROP  = SUM_W - OUT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bin_ack = 1'b0;
  logic signed [BIN_W-1:0] bin_data = '0;
  logic [PAD_W-1:0] bin_pad = '0;
  logic bin_req, bit_valid, done;
  logic [IDX_W-1:0] bin_idx;
  logic [STEP-1:0] bit_data;
  logic [SUM_W-1:0] sum_out;
  logic [OUT_W-1:0] rnd_out;

  int nchk = 0;
  int nfail = 0;
  logic signed [BIN_W-1:0] bv [NBINS];
  int pv [NBINS];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bin_recon #(.NBINS(NBINS), .BIN_W(BIN_W), .GRP_K(GRP_K), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bin_req(bin_req), .bin_idx(bin_idx),
    .bin_ack(bin_ack), .bin_data(bin_data), .bin_pad(bin_pad), .bit_valid(bit_valid),
    .bit_data(bit_data), .sum_out(sum_out), .rnd_out(rnd_out), .done(done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_bins();
    for (int i = 0; i < NBINS; i++) begin
      bv[i] = '0;
      pv[i] = 0;
    end
  endtask

  task automatic run_case(input string name, input int lat, input bit poke);
    longint e, q, rem, half;
    int idx_bad, bit_bad;
    logic [SUM_W-1:0] held;
    e = 0;
    for (int i = 0; i < NBINS; i++)
      e += longint'(bv[i]) <<< (pv[i] + i * STEP);
    q = e >>> DROP;
    rem = e - (q <<< DROP);
    half = longint'(1) <<< (DROP - 1);
    if (rem > half || (rem == half && q[0])) q++;
    idx_bad = 0;
    bit_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < NBINS; i++) begin
      while (!bin_req) @(negedge clk);
      if (bin_idx != IDX_W'(i)) idx_bad++;
      for (int w = 0; w < lat; w++) begin
        start = poke && (i == NBINS / 2) && (w == 0);
        @(negedge clk);
        start = 1'b0;
        if (!bin_req || bin_idx != IDX_W'(i)) idx_bad++;
      end
      bin_ack = 1'b1;
      bin_data = bv[i];
      bin_pad = PAD_W'(pv[i]);
      @(negedge clk);
      bin_ack = 1'b0;
      if (!bit_valid || longint'(bit_data) != ((e >>> (i * STEP)) & ((longint'(1) <<< STEP) - 1)))
        bit_bad++;
    end
    chk(idx_bad == 0, {"R1 index order ", name}, idx_bad, 0);
    chk(bit_bad == 0, {"R2 serial chunks ", name}, bit_bad, 0);
    @(negedge clk);
    chk(done == 1'b1, {"R6 done pulse ", name}, done, 1);
    chk(sum_out == SUM_W'(e), {"R3 exact sum ", name}, longint'(sum_out), e & ((longint'(1) <<< SUM_W) - 1));
    chk(rnd_out == OUT_W'(q), {"R5 rounded ", name}, longint'(rnd_out), q & ((longint'(1) <<< OUT_W) - 1));
    held = sum_out;
    @(negedge clk);
    chk(done == 1'b0 && sum_out == held, {"R6 done drop and hold ", name}, done, 0);
  endtask

  task automatic t_reset();
    chk(!bin_req && !bit_valid && !done && sum_out == '0 && rnd_out == '0,
        "R8 reset state", longint'(sum_out) + longint'(done), 0);
  endtask

  task automatic t_ramp();
    clear_bins();
    for (int i = 0; i < NBINS; i++) bv[i] = BIN_W'(i * 37 + 5);
    run_case("ramp", 0, 1'b0);
  endtask

  task automatic t_negative();
    clear_bins();
    for (int i = 0; i < NBINS; i++) bv[i] = (i % 3 == 0) ? BIN_W'(-700 - i) : BIN_W'(90 + i);
    bv[NBINS-1] = BIN_W'(-2048);
    run_case("negative mix", 2, 1'b0);
  endtask

  task automatic t_ties();
    clear_bins();
    bv[NBINS-1] = BIN_W'(2);
    run_case("R5 tie to even down", 1, 1'b0);
    bv[NBINS-1] = BIN_W'(6);
    run_case("R5 tie to even up", 0, 1'b0);
    bv[NBINS-1] = BIN_W'(2);
    bv[0] = BIN_W'(1);
    run_case("R5 sticky above half", 0, 1'b0);
    clear_bins();
    bv[NBINS-1] = BIN_W'(-2);
    run_case("R5 negative tie", 1, 1'b0);
  endtask

  task automatic t_pad();
    clear_bins();
    for (int i = 0; i < NBINS; i++) begin
      bv[i] = BIN_W'((i % 2 == 0) ? 3 * i + 1 : -(2 * i + 3));
      pv[i] = i % 5;
    end
    run_case("R4 padded bins", 1, 1'b0);
  endtask

  task automatic t_busy_start();
    clear_bins();
    for (int i = 0; i < NBINS; i++) bv[i] = BIN_W'(1000 - 130 * i);
    run_case("R7 busy start ignored", 2, 1'b1);
    clear_bins();
    bv[3] = BIN_W'(1);
    run_case("R7 fresh pass cleared", 0, 1'b0);
  endtask

  task automatic t_random();
    for (int r = 0; r < 3; r++) begin
      clear_bins();
      for (int i = 0; i < NBINS; i++) bv[i] = BIN_W'($urandom);
      run_case("R3 random", r, 1'b0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    clear_bins();
    run_case("R3 zeros", 0, 1'b0);
    t_ramp();
    t_negative();
    t_ties();
    t_pad();
    t_busy_start();
    t_random();
    summary();
    $finish;
  end
endmodule